// File: doc/BRIEF.md
# Packed Vector Immediate Shifter

This unit shifts a 128-bit vector operand by an unsigned 8-bit immediate count. A 3-bit operation selector and a 2-bit lane-size code choose between per-lane shifts and whole-register byte shifts. The per-lane shifts are logical right, arithmetic right and left, on 16, 32 or 64-bit lanes. The byte shifts move whole bytes across the full register, so bytes pass from one 64-bit half into the other. Selector and lane-size combinations that name no operation raise an invalid flag.

The operation is captured on a rising clock edge while the input strobe is high. The result and the flag appear on registered outputs, and the output strobe is high for the following cycle. A count of the lane width or more does not wrap. Logical shifts then give zero lanes, and arithmetic shifts fill each lane with its own sign bit.

Top module: `vec_shift_imm`

## Requirements
- R1: While reset is high, and after it until the first accepted operation, `out_valid`, `illegal` and `result` are all zero.
- R2: An operation is accepted on a rising edge with `in_valid` high. `out_valid` is high exactly in the following cycle, and `result` and `illegal` hold their values while no new operation is accepted.
- R3: Selector 2 shifts every lane right logically by the count. Lane code 1 means 16-bit lanes, code 2 means 32-bit lanes and code 3 means 64-bit lanes.
- R4: Selector 6 shifts every lane left by the count and fills the vacated low bits with zero.
- R5: Selector 4 shifts every lane right by the count and copies the lane's top bit into the vacated high bits.
- R6: For selectors 2 and 6, a count equal to or above the lane width gives all-zero lanes. The count is unsigned, so 200 also counts as oversized.
- R7: For selector 4, a count equal to or above the lane width fills each lane with copies of that lane's top bit.
- R8: With lane code 3, selector 3 shifts the whole 128-bit register right by count bytes and selector 7 shifts it left by count bytes. Bytes cross the 64-bit half boundary.
- R9: A byte shift by 0 returns the operand unchanged. A byte shift by 16 or more returns zero.
- R10: A byte shift by 8 to 15 places the other half, shifted by count mod 8 bytes, into the receiving half and zeroes the vacated half.
- R11: Any other pair of selector and lane code sets `illegal` and returns a zero result. This covers selectors 0, 1 and 5, lane code 0 with a per-lane selector, and selectors 3 or 7 with a lane code other than 3. A legal operation clears `illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept strobe for the operation on the inputs |
| op_sel | input | 3 | Operation selector |
| lane_sz | input | 2 | Lane-size code |
| count | input | 8 | Unsigned shift count (bits, or bytes for byte shifts) |
| operand | input | 128 | Vector to shift |
| out_valid | output | 1 | High one cycle after an accepted operation |
| result | output | 128 | Registered shifted vector |
| illegal | output | 1 | Registered invalid-operation flag |

## Verification
The bench targets the count boundaries: one below the lane width, exactly the lane width, and far above it at 200 and 255. A design that masks the count to the lane's shift width would wrap and return a partly shifted lane instead of zeros or a sign fill. For byte shifts the bench uses counts of 0, 3, 5, 8, 11, 16 and 255 with distinct byte values. A design that shifts each half on its own would lose the bytes that should cross the middle, and one that wraps at 16 would return data where zeros are due. Negative lanes in the arithmetic cases expose a zero fill used where a sign fill is required. The undefined selector and lane combinations expose a decoder that lets a wrong lane size or selector through.

// File: rtl/vsh_pkg.sv
package vsh_pkg;
  localparam logic [2:0] SEL_SRL = 3'd2;
  localparam logic [2:0] SEL_BSR = 3'd3;
  localparam logic [2:0] SEL_SRA = 3'd4;
  localparam logic [2:0] SEL_SLL = 3'd6;
  localparam logic [2:0] SEL_BSL = 3'd7;

  typedef enum logic [1:0] {
    KIND_SRL = 2'd0,
    KIND_SRA = 2'd1,
    KIND_SLL = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/vsh_lane_unit.sv
module vsh_lane_unit
  import vsh_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic [VEC_W-1:0] vec,
  input  logic [CNT_W-1:0] cnt,
  input  shift_kind_e      kind,
  output logic [VEC_W-1:0] res
);
  localparam int NLANE = VEC_W / LANE_W;
  localparam int SH_W  = $clog2(LANE_W);

  logic            oversize;
  logic [SH_W-1:0] amt;

  assign oversize = (32'(cnt) >= LANE_W);
  assign amt      = cnt[SH_W-1:0];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] ln;
    logic [LANE_W-1:0] o;
    assign ln = vec[g*LANE_W +: LANE_W];
    always_comb begin
      case (kind)
        KIND_SRA: o = oversize ? {LANE_W{ln[LANE_W-1]}}
                               : LANE_W'($signed(ln) >>> amt);
        KIND_SLL: o = oversize ? '0 : (ln << amt);
        default:  o = oversize ? '0 : (ln >> amt);
      endcase
    end
    assign res[g*LANE_W +: LANE_W] = o;
  end
endmodule

// File: rtl/vsh_byte_unit.sv
module vsh_byte_unit #(
  parameter int VEC_W = 128,
  parameter int CNT_W = 8
) (
  input  logic [VEC_W-1:0] vec,
  input  logic [CNT_W-1:0] cnt,
  input  logic             left,
  output logic [VEC_W-1:0] res
);
  localparam int NBYTE = VEC_W / 8;
  localparam int BA_W  = $clog2(NBYTE);

  logic            oversize;
  logic [BA_W+2:0] bit_amt;

  assign oversize = (32'(cnt) >= NBYTE);
  assign bit_amt  = {cnt[BA_W-1:0], 3'b000};

  always_comb begin
    if (oversize)  res = '0;
    else if (left) res = vec << bit_amt;
    else           res = vec >> bit_amt;
  end
endmodule

// File: rtl/vec_shift_imm.sv
module vec_shift_imm
  import vsh_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       op_sel,
  input  logic [1:0]       lane_sz,
  input  logic [CNT_W-1:0] count,
  input  logic [VEC_W-1:0] operand,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             illegal
);
  localparam int NSIZE = 3;

  logic             lane_op, byte_op, bad;
  shift_kind_e      kind;
  logic [VEC_W-1:0] lane_res [NSIZE];
  logic [VEC_W-1:0] byte_res;
  logic [VEC_W-1:0] sel_res;
  logic [VEC_W-1:0] nxt_res;

  always_comb begin
    lane_op = ((op_sel == SEL_SRL) || (op_sel == SEL_SRA) || (op_sel == SEL_SLL))
              && (lane_sz != 2'd0);
    byte_op = ((op_sel == SEL_BSR) || (op_sel == SEL_BSL)) && (lane_sz == 2'd3);
    bad     = !(lane_op || byte_op);
    case (op_sel)
      SEL_SRA: kind = KIND_SRA;
      SEL_SLL: kind = KIND_SLL;
      default: kind = KIND_SRL;
    endcase
  end

  for (genvar k = 0; k < NSIZE; k++) begin : g_size
    vsh_lane_unit #(
      .VEC_W (VEC_W),
      .LANE_W(16 << k),
      .CNT_W (CNT_W)
    ) u_lane (
      .vec (operand),
      .cnt (count),
      .kind(kind),
      .res (lane_res[k])
    );
  end

  vsh_byte_unit #(
    .VEC_W(VEC_W),
    .CNT_W(CNT_W)
  ) u_byte (
    .vec (operand),
    .cnt (count),
    .left(op_sel == SEL_BSL),
    .res (byte_res)
  );

  always_comb begin
    case (lane_sz)
      2'd1:    sel_res = lane_res[0];
      2'd2:    sel_res = lane_res[1];
      default: sel_res = lane_res[2];
    endcase
    if (bad)          nxt_res = '0;
    else if (byte_op) nxt_res = byte_res;
    else              nxt_res = sel_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt_res;
        illegal <= bad;
      end
    end
  end
endmodule

// File: rtl/vsh_checker.sv
module vsh_checker #(
  parameter int VEC_W = 128,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [2:0]       op_sel,
  input logic [1:0]       lane_sz,
  input logic [CNT_W-1:0] count,
  input logic [VEC_W-1:0] operand,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             illegal
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && !illegal && result == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(illegal)));

  // R9
  byte_zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd3 && lane_sz == 2'd3 && count == '0) |=> (result == $past(operand)));

  // R9
  byte_big_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_sel == 3'd3 || op_sel == 3'd7) && lane_sz == 2'd3 && 32'(count) >= 16)
    |=> (result == '0 && !illegal));

  // R11
  bad_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_sel == 3'd0 || op_sel == 3'd1 || op_sel == 3'd5)) |=> illegal);

  // R11
  bad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (result == '0));
endmodule

bind vec_shift_imm vsh_checker #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op_sel   (op_sel),
  .lane_sz  (lane_sz),
  .count    (count),
  .operand  (operand),
  .out_valid(out_valid),
  .result   (result),
  .illegal  (illegal)
);

// File: tb/sim_vec_shift_imm.sv
module sim_vec_shift_imm;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   op_sel = '0;
  logic [1:0]   lane_sz = '0;
  logic [7:0]   count = '0;
  logic [127:0] operand = '0;
  logic         out_valid;
  logic [127:0] result;
  logic         illegal;

  typedef struct {
    logic [127:0] res;
    logic         ill;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  vec_shift_imm u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .lane_sz(lane_sz),
    .count(count), .operand(operand), .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  function automatic void model(input logic [2:0] op, input logic [1:0] ls, input logic [7:0] c,
                                input logic [127:0] v, output logic [127:0] r, output logic ill);
    int w;
    logic [63:0] mask, ln, o;
    r = '0; ill = 1'b0;
    if ((op == 3 || op == 7) && ls == 3) begin
      if (c >= 16) r = '0;
      else if (op == 7) r = v << (c * 8);
      else r = v >> (c * 8);
    end else if ((op == 2 || op == 4 || op == 6) && ls != 0) begin
      w = 8 << ls;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
      for (int i = 0; i < 128 / w; i++) begin
        ln = (v >> (i * w)) & 128'(mask);
        if (op == 2) o = (c >= w) ? 64'd0 : (ln >> c);
        else if (op == 6) o = (c >= w) ? 64'd0 : ((ln << c) & mask);
        else begin
          if (c >= w) o = ln[w-1] ? mask : 64'd0;
          else o = (ln >> c) | (ln[w-1] ? (mask & ~(mask >> c)) : 64'd0);
        end
        r = r | (128'(o) << (i * w));
      end
    end else begin
      ill = 1'b1;
    end
  endfunction

  task automatic fail_line(string tag, logic [127:0] act, logic [127:0] exp, logic ai, logic ei);
    errors++;
    $display("FAIL %s: result=%h illegal=%0b expected result=%h illegal=%0b", tag, act, ai, exp, ei);
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] ls, input logic [7:0] c,
                       input logic [127:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    op_sel = op; lane_sz = ls; count = c; operand = v; in_valid = 1'b1;
    model(op, ls, c, v, e.res, e.ill);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: pops one expected item for each output strobe
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) fail_line("R2 unexpected out_valid", result, '0, illegal, 1'b0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        if (result !== e.res || illegal !== e.ill) fail_line(e.tag, result, e.res, illegal, e.ill);
      end
    end
  end

  localparam logic [127:0] PAT  = 128'h8F1E_2D3C_4B5A_6978_F0E1_D2C3_B4A5_9687;
  localparam logic [127:0] BYTS = 128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || illegal !== 1'b0 || result !== '0)
      fail_line("R1 reset state", result, '0, illegal, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0) fail_line("R1 after reset", result, '0, illegal, 1'b0);

    drive(3'd2, 2'd1, 8'd4,   PAT, "R3 srl16 by 4");
    drive(3'd2, 2'd2, 8'd31,  PAT, "R3 srl32 by 31");
    drive(3'd2, 2'd3, 8'd63,  PAT, "R3 srl64 by 63");
    drive(3'd6, 2'd1, 8'd1,   PAT, "R4 sll16 by 1");
    drive(3'd6, 2'd3, 8'd12,  PAT, "R4 sll64 by 12");
    drive(3'd4, 2'd1, 8'd3,   PAT, "R5 sra16 by 3");
    drive(3'd4, 2'd2, 8'd0,   PAT, "R5 sra32 by 0");
    drive(3'd4, 2'd3, 8'd40,  PAT, "R5 sra64 by 40");
    drive(3'd2, 2'd1, 8'd16,  PAT, "R6 srl16 by 16");
    drive(3'd6, 2'd2, 8'd200, PAT, "R6 sll32 by 200");
    drive(3'd2, 2'd3, 8'd64,  PAT, "R6 srl64 by 64");
    drive(3'd4, 2'd1, 8'd16,  PAT, "R7 sra16 by 16");
    drive(3'd4, 2'd3, 8'd255, PAT, "R7 sra64 by 255");
    drive(3'd4, 2'd2, 8'd32,  PAT, "R7 sra32 by 32");
    drive(3'd3, 2'd3, 8'd3,   BYTS, "R8 byte right 3");
    drive(3'd7, 2'd3, 8'd5,   BYTS, "R8 byte left 5");
    drive(3'd3, 2'd3, 8'd0,   BYTS, "R9 byte right 0");
    drive(3'd7, 2'd3, 8'd16,  BYTS, "R9 byte left 16");
    drive(3'd3, 2'd3, 8'd255, BYTS, "R9 byte right 255");
    drive(3'd3, 2'd3, 8'd8,   BYTS, "R10 byte right 8");
    drive(3'd7, 2'd3, 8'd11,  BYTS, "R10 byte left 11");
    drive(3'd0, 2'd3, 8'd1,   PAT, "R11 selector 0");
    drive(3'd5, 2'd2, 8'd1,   PAT, "R11 selector 5");
    drive(3'd2, 2'd0, 8'd1,   PAT, "R11 lane code 0");
    drive(3'd3, 2'd2, 8'd1,   PAT, "R11 byte right lane 2");
    drive(3'd7, 2'd1, 8'd1,   PAT, "R11 byte left lane 1");
    drive(3'd6, 2'd2, 8'd4,   PAT, "R11 legal op clears flag");

    @(negedge clk);
    in_valid = 1'b0;
    operand = '1; op_sel = 3'd0;
    repeat (2) @(negedge clk);
    begin
      logic [127:0] er; logic ei;
      model(3'd6, 2'd2, 8'd4, PAT, er, ei);
      checks++;
      if (out_valid !== 1'b0 || result !== er || illegal !== ei)
        fail_line("R2 hold while idle", result, er, illegal, ei);
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule